// File: doc/BRIEF.md
# Serial Burst Data Engine with CRC-32 Framing

This block carries the data phase of a debug memory burst across a bit-serial scan path. A command decoder elsewhere loads the direction, the word size, the word count and the start address. After that, each pulse of `shift_en` moves one bit: the host's bit arrives on `scan_in` and the engine's bit leaves on `scan_out`. Both directions are protected by a reflected CRC-32. The CRC starts from all ones and is advanced one bit at a time, with the low bit of each byte first.

In a write burst, the engine skips any zero bits that come before the first 1. After that start bit it assembles payload words. Each finished word goes out on a simple request/grant port to the local bus. Once the payload is in, the engine takes the host's 32-bit CRC and returns a single bit that tells whether the two CRC values agree.

In a read burst, the engine prefetches words from the local bus. It sends zeros until the first word is held, then one marker bit, then the payload, and last its own CRC of that payload. If a following word arrives too late, the engine flags an underrun, because after the marker the stream cannot pause.

Top module: `dbg_burst_engine`

## Requirements
- R1: The CRC register starts at 0xFFFFFFFF. On each payload bit it shifts right by one, and it is XORed with 0xEDB88320 when that bit differs from the register's current bit 0. Every payload byte is fed bit 0 first.
- R2: In a write burst, zero bits on `scan_in` before the first 1 are discarded. The payload starts with the bit after that first 1.
- R3: After the write payload, 32 CRC bits follow, bit 0 first. On the next shift, `scan_out` is 1 if that value equals the CRC computed over the payload, and 0 if it does not.
- R4: Each completed write word appears on `bus_wdata`, right-aligned, with `bus_we`=1. The first payload byte sits in bits 7:0. `bus_req` and `bus_addr` hold steady until `bus_gnt` is seen.
- R5: In a read burst, `scan_out` is 0 while the first word is not yet held. It shows a single 1 on the shift after that word becomes available.
- R6: After the read marker, the payload leaves bit 0 first with words in little-endian byte order. It is followed by the CRC-32 of the payload, bit 0 first.
- R7: Size code 0 selects 1-byte words, code 1 selects 2-byte words, and codes 2 and 3 select 4-byte words. `bus_size` shows 0, 1 or 2, and the bus address advances by the word's byte count after each grant.
- R8: A word count of 0 carries no payload. A write goes straight from its start bit to the CRC bits and compares them against 0xFFFFFFFF. A read gives its marker on the first shift and then sends 0xFFFFFFFF.
- R9: Waiting before the marker never sets `underrun`. If the next read word is not held when the last bit of the current word shifts, `underrun` is set and stays set until the next command load.
- R10: A command load at any point restarts the engine. It clears `underrun`, reloads the CRC to all ones, and drops any partly received word.
- R11: During and right after reset, `scan_out`, `bus_req` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Loads the burst parameters and restarts the engine |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_size | input | 2 | Word size code |
| cmd_count | input | CNT_W | Number of words in the burst |
| cmd_addr | input | ADDR_W | Byte address of the first word |
| shift_en | input | 1 | Moves one bit on the scan path this cycle |
| scan_in | input | 1 | Serial bit from the host |
| scan_out | output | 1 | Serial bit to the host, valid before each shift |
| underrun | output | 1 | Sticky flag: a read word arrived late |
| bus_req | output | 1 | Local bus request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Local bus byte address |
| bus_size | output | 2 | Normalised size code of the access |
| bus_wdata | output | 32 | Write word, right-aligned |
| bus_rdata | input | 32 | Read word, right-aligned |
| bus_gnt | input | 1 | Request accepted; read data is valid with it |

## Verification
The bench builds the engine with `ADDR_W` set to 16 and `CNT_W` left at 16. Short addresses keep the bus model's data pattern easy to predict. The bench drives the full size-code range, including the aliased code 3, and a zero word count, so the CRC value of an empty payload becomes observable. The bus model's grant latency can be changed per burst. A small latency keeps reads ahead of the shift rate. A long latency shows zeros before the marker and forces a late word after it, which exercises the underrun flag and its clearing by the next command.

// File: rtl/dbg_burst_pkg.sv
package dbg_burst_pkg;

  localparam int WORD_W = 32;
  localparam int CRC_W  = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_HUNT,
    ST_W_DATA,
    ST_W_CRC,
    ST_W_MATCH,
    ST_R_WAIT,
    ST_R_DATA,
    ST_R_CRC,
    ST_DONE
  } burst_state_e;

  // Code 3 aliases the widest word.
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [5:0] size_bits(input logic [1:0] code);
    return {size_bytes(code), 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    return WORD_W'(32'h0000_00FF);
      2'd1:    return WORD_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  // One serial step of the reflected CRC.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic d,
                                                input logic [CRC_W-1:0] poly);
    return (c >> 1) ^ ((c[0] ^ d) ? poly : '0);
  endfunction

endpackage

// File: rtl/burst_crc.sv
module burst_crc import dbg_burst_pkg::*; #(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  input  logic             drain,
  output logic [CRC_W-1:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '1;
    else if (init)  crc <= '1;
    else if (step)  crc <= crc_step(crc, din, POLY);
    else if (drain) crc <= {1'b0, crc[CRC_W-1:1]};
  end

endmodule

// File: rtl/burst_counter.sv
module burst_counter import dbg_burst_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int BIT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic [1:0]       size_code,
  input  logic             step,
  input  logic             data_phase,
  output logic [BIT_W-1:0] bit_idx,
  output logic [CNT_W-1:0] words_left,
  output logic             word_end,
  output logic             crc_end,
  output logic             last_word,
  output logic             words_zero
);

  assign word_end   = (bit_idx == BIT_W'(size_bits(size_code) - 6'd1));
  assign crc_end    = (bit_idx == BIT_W'(CRC_W - 1));
  assign words_zero = (words_left == '0);
  assign last_word  = (words_left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx    <= '0;
      words_left <= '0;
    end else if (load) begin
      bit_idx    <= '0;
      words_left <= load_count;
    end else if (step) begin
      if (data_phase && word_end) begin
        bit_idx <= '0;
        if (!words_zero) words_left <= words_left - CNT_W'(1);
      end else begin
        bit_idx <= bit_idx + BIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/burst_busport.sv
module burst_busport import dbg_burst_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [1:0]        size_code,
  input  logic              wr_push,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_gnt
);

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] buf_q;
  logic              full_q;
  logic              we_q;
  logic [CNT_W-1:0]  fetch_left;
  logic              granted;

  assign bus_req   = we_q ? full_q : (!full_q && (fetch_left != '0));
  assign granted   = bus_req && bus_gnt;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = buf_q;
  assign rd_valid  = full_q && !we_q;
  assign rd_word   = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      buf_q      <= '0;
      full_q     <= 1'b0;
      we_q       <= 1'b0;
      fetch_left <= '0;
    end else if (start) begin
      addr_q     <= start_addr;
      full_q     <= 1'b0;
      we_q       <= start_write;
      fetch_left <= start_write ? '0 : start_count;
    end else begin
      if (granted) begin
        addr_q <= addr_q + ADDR_W'(size_bytes(size_code));
        if (we_q) begin
          full_q <= 1'b0;
        end else begin
          buf_q      <= bus_rdata & size_mask(size_code);
          full_q     <= 1'b1;
          fetch_left <= fetch_left - CNT_W'(1);
        end
      end
      if (wr_push) begin
        buf_q  <= wr_word;
        full_q <= 1'b1;
      end
      if (rd_pop) full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_burst_engine.sv
module dbg_burst_engine import dbg_burst_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_size,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              shift_en,
  input  logic              scan_in,
  output logic              scan_out,
  output logic              underrun,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_gnt
);

  localparam int BIT_W = $clog2(WORD_W) + 1;

  burst_state_e      state, nxt;
  logic [1:0]        size_q;
  logic [WORD_W-1:0] word_sh, wr_word, rd_word;
  logic [CRC_W-1:0]  rx_crc, crc_val;
  logic              underrun_q;
  logic [BIT_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  words_left;
  logic              word_end, crc_end, last_word, words_zero, rd_valid;

  // Named internal events
  logic crc_step_en, crc_din, crc_drain, cnt_step, data_phase;
  logic wr_push, rd_pop, load_sh, ev_underrun, scan_out_c;

  burst_crc #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(cmd_load), .step(crc_step_en),
    .din(crc_din), .drain(crc_drain), .crc(crc_val)
  );

  burst_counter #(.CNT_W(CNT_W), .BIT_W(BIT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cmd_load), .load_count(cmd_count),
    .size_code(size_q), .step(cnt_step), .data_phase(data_phase),
    .bit_idx(bit_idx), .words_left(words_left), .word_end(word_end),
    .crc_end(crc_end), .last_word(last_word), .words_zero(words_zero)
  );

  burst_busport #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(cmd_load), .start_write(cmd_write),
    .start_addr(cmd_addr), .start_count(cmd_count), .size_code(size_q),
    .wr_push(wr_push), .wr_word(wr_word), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_word(rd_word), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_gnt(bus_gnt)
  );

  assign wr_word  = word_sh | (WORD_W'(scan_in) << bit_idx);
  assign scan_out = scan_out_c;
  assign underrun = underrun_q;
  assign bus_size = size_q;

  always_comb begin
    nxt         = state;
    crc_step_en = 1'b0;
    crc_din     = 1'b0;
    crc_drain   = 1'b0;
    cnt_step    = 1'b0;
    data_phase  = 1'b0;
    wr_push     = 1'b0;
    rd_pop      = 1'b0;
    load_sh     = 1'b0;
    ev_underrun = 1'b0;
    scan_out_c  = 1'b0;
    if (cmd_load) begin
      nxt = cmd_write ? ST_W_HUNT : ST_R_WAIT;
    end else begin
      case (state)
        ST_W_HUNT: begin
          if (shift_en && scan_in) nxt = words_zero ? ST_W_CRC : ST_W_DATA;
        end
        ST_W_DATA: begin
          data_phase = 1'b1;
          if (shift_en) begin
            crc_step_en = 1'b1;
            crc_din     = scan_in;
            cnt_step    = 1'b1;
            if (word_end) begin
              wr_push = 1'b1;
              if (last_word) nxt = ST_W_CRC;
            end
          end
        end
        ST_W_CRC: begin
          if (shift_en) begin
            cnt_step = 1'b1;
            if (crc_end) nxt = ST_W_MATCH;
          end
        end
        ST_W_MATCH: begin
          scan_out_c = (crc_val == rx_crc);
          if (shift_en) nxt = ST_DONE;
        end
        ST_R_WAIT: begin
          scan_out_c = rd_valid || words_zero;
          if (shift_en && scan_out_c) begin
            if (words_zero) begin
              nxt = ST_R_CRC;
            end else begin
              rd_pop  = 1'b1;
              load_sh = 1'b1;
              nxt     = ST_R_DATA;
            end
          end
        end
        ST_R_DATA: begin
          data_phase = 1'b1;
          scan_out_c = word_sh[0];
          if (shift_en) begin
            crc_step_en = 1'b1;
            crc_din     = word_sh[0];
            cnt_step    = 1'b1;
            if (word_end) begin
              if (last_word) begin
                nxt = ST_R_CRC;
              end else if (rd_valid) begin
                rd_pop  = 1'b1;
                load_sh = 1'b1;
              end else begin
                ev_underrun = 1'b1;
              end
            end
          end
        end
        ST_R_CRC: begin
          scan_out_c = crc_val[0];
          if (shift_en) begin
            crc_drain = 1'b1;
            cnt_step  = 1'b1;
            if (crc_end) nxt = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      size_q     <= 2'd0;
      word_sh    <= '0;
      rx_crc     <= '0;
      underrun_q <= 1'b0;
    end else begin
      state <= nxt;
      if (cmd_load) begin
        size_q     <= norm_size(cmd_size);
        word_sh    <= '0;
        rx_crc     <= '0;
        underrun_q <= 1'b0;
      end else begin
        if (wr_push)
          word_sh <= '0;
        else if (state == ST_W_DATA && shift_en)
          word_sh <= wr_word;
        else if (load_sh)
          word_sh <= rd_word;
        else if (state == ST_R_DATA && shift_en)
          word_sh <= {1'b0, word_sh[WORD_W-1:1]};
        if (state == ST_W_CRC && shift_en)
          rx_crc <= {scan_in, rx_crc[CRC_W-1:1]};
        if (ev_underrun) underrun_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbg_burst_chk.sv
module dbg_burst_chk import dbg_burst_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_load,
  input logic              shift_en,
  input logic              scan_out,
  input logic              underrun,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input burst_state_e      state,
  input logic [CRC_W-1:0]  crc_val,
  input logic [CNT_W-1:0]  words_left
);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !cmd_load) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !cmd_load) |=>
      (bus_addr == $past(bus_addr) + ADDR_W'(size_bytes($past(bus_size)))));

  assert_crc_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (crc_val == '1));

  assert_underrun_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(state) == ST_R_DATA));

  assert_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_R_DATA && $past(state) == ST_R_WAIT) |-> ($past(scan_out) && $past(shift_en)));

  assert_words_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_load) |-> (words_left <= $past(words_left)));

endmodule

bind dbg_burst_engine dbg_burst_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .shift_en(shift_en),
  .scan_out(scan_out), .underrun(underrun), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .state(state),
  .crc_val(crc_val), .words_left(words_left)
);

// File: tb/dbg_burst_engine_tb.sv
`timescale 1ns/1ps
module dbg_burst_engine_tb;

  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_load = 1'b0, cmd_write = 1'b0;
  logic [1:0]    cmd_size = 2'd0;
  logic [CW-1:0] cmd_count = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          shift_en = 1'b0, scan_in = 1'b0;
  logic          scan_out, underrun, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata = '0;
  logic          bus_gnt = 1'b0;

  dbg_burst_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_write(cmd_write),
    .cmd_size(cmd_size), .cmd_count(cmd_count), .cmd_addr(cmd_addr),
    .shift_en(shift_en), .scan_in(scan_in), .scan_out(scan_out),
    .underrun(underrun), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_gnt(bus_gnt)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 1;
  int wait_cnt = 0;
  int n_log    = 0;
  logic [AW-1:0] log_addr [0:63];
  logic [31:0]   log_data [0:63];
  logic [1:0]    log_size [0:63];
  logic [7:0]    pay [0:255];

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h6D, a[7:0] + 8'h11, ~a[7:0], a[7:0] ^ 8'hC3};
  endfunction

  function automatic int bsz(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int j = 0; j < n; j++)
      for (int b = 0; b < 8; b++)
        c = (c[0] != pay[j][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return c;
  endfunction

  // Bus responder: grant after lat cycles of waiting
  always @(negedge clk) begin
    if (bus_gnt) begin
      bus_gnt = 1'b0;
    end else if (!bus_req) begin
      wait_cnt = 0;
    end else if (wait_cnt >= lat) begin
      bus_gnt   = 1'b1;
      wait_cnt  = 0;
      bus_rdata = mem_word(bus_addr);
      if (bus_we && n_log < 64) begin
        log_addr[n_log] = bus_addr;
        log_data[n_log] = bus_wdata;
        log_size[n_log] = bus_size;
        n_log++;
      end
    end else begin
      wait_cnt++;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic issue(input logic wr, input logic [1:0] sz, input int cnt,
                       input logic [AW-1:0] adr);
    @(negedge clk);
    cmd_write = wr; cmd_size = sz; cmd_count = CW'(cnt); cmd_addr = adr;
    cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic shift1(input logic din, output logic dout);
    @(negedge clk);
    dout = scan_out; scan_in = din; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; scan_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_burst(input logic [1:0] sz, input int cnt, input logic [AW-1:0] adr,
                          input int lead, input logic bad, output logic m);
    int s, n;
    logic d;
    logic [31:0] c;
    s = bsz(sz); n = cnt * s;
    for (int j = 0; j < n; j++) pay[j] = 8'(adr[7:0] * 37 + j * 13 + 5);
    issue(1'b1, sz, cnt, adr);
    n_log = 0;
    for (int i = 0; i < lead; i++) shift1(1'b0, d);
    shift1(1'b1, d);
    for (int j = 0; j < n; j++)
      for (int b = 0; b < 8; b++) shift1(pay[j][b], d);
    c = crc_of(n);
    if (bad) c[0] = ~c[0];
    for (int i = 0; i < 32; i++) shift1(c[i], d);
    shift1(1'b0, m);
    repeat (lat + 6) @(negedge clk);
  endtask

  task automatic wr_words_check(input logic [1:0] sz, input int cnt, input logic [AW-1:0] adr);
    int s;
    logic [31:0] w;
    s = bsz(sz);
    check(n_log == cnt, "R4 write word count", 32'(n_log), 32'(cnt));
    for (int k = 0; k < cnt && k < n_log; k++) begin
      w = '0;
      for (int b = 0; b < s; b++) w = w | (32'(pay[k*s+b]) << (8*b));
      check(log_data[k] == w, "R4 write word data", log_data[k], w);
      check(log_addr[k] == AW'(adr + AW'(k*s)), "R7 write address", 32'(log_addr[k]),
            32'(adr + AW'(k*s)));
      check(log_size[k] == ((sz == 2'd3) ? 2'd2 : sz), "R7 bus size", 32'(log_size[k]),
            32'((sz == 2'd3) ? 2'd2 : sz));
    end
  endtask

  task automatic rd_burst(input logic [1:0] sz, input int cnt, input logic [AW-1:0] adr,
                          output int zeros, output logic marker, output int bad_bits,
                          output logic [31:0] crc_got);
    int s, n;
    logic d;
    logic [31:0] w;
    s = bsz(sz); n = cnt * s;
    for (int k = 0; k < cnt; k++) begin
      w = mem_word(AW'(adr + AW'(k*s)));
      for (int b = 0; b < s; b++) pay[k*s+b] = w[8*b +: 8];
    end
    issue(1'b0, sz, cnt, adr);
    zeros = 0; marker = 1'b0; bad_bits = 0;
    for (int i = 0; i < 200 && !marker; i++) begin
      shift1(1'b0, d);
      if (d) marker = 1'b1; else zeros++;
    end
    for (int j = 0; j < n; j++)
      for (int b = 0; b < 8; b++) begin
        shift1(1'b0, d);
        if (d !== pay[j][b]) bad_bits++;
      end
    for (int i = 0; i < 32; i++) begin
      shift1(1'b0, d);
      crc_got[i] = d;
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  cnt;
    logic [15:0] adr;
    logic [3:0]  lead;
    logic [3:0]  lt;
    logic        bad;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b1, 2'd2, 8'd3, 16'h1000, 4'd0, 4'd1, 1'b0},
    '{1'b1, 2'd0, 8'd5, 16'h2003, 4'd3, 4'd0, 1'b0},
    '{1'b1, 2'd1, 8'd4, 16'h0040, 4'd7, 4'd2, 1'b0},
    '{1'b1, 2'd2, 8'd2, 16'h0100, 4'd1, 4'd1, 1'b1},
    '{1'b0, 2'd2, 8'd3, 16'h3000, 4'd0, 4'd1, 1'b0},
    '{1'b0, 2'd0, 8'd6, 16'h0051, 4'd0, 4'd0, 1'b0},
    '{1'b0, 2'd1, 8'd4, 16'h0082, 4'd0, 4'd2, 1'b0},
    '{1'b0, 2'd3, 8'd2, 16'h0200, 4'd0, 4'd1, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic m, mk, d;
    int zeros, badb;
    logic [31:0] cg;

    repeat (3) @(negedge clk);
    // R11: reset state
    check(scan_out == 1'b0, "R11 scan_out in reset", 32'(scan_out), 0);
    check(bus_req == 1'b0, "R11 bus_req in reset", 32'(bus_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(underrun == 1'b0 && scan_out == 1'b0, "R11 idle after reset",
          32'({underrun, scan_out}), 0);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      lat = int'(VEC[v].lt);
      if (VEC[v].wr) begin
        wr_burst(VEC[v].sz, int'(VEC[v].cnt), VEC[v].adr, int'(VEC[v].lead), VEC[v].bad, m);
        check(m == !VEC[v].bad, "R1 R2 R3 write match bit", 32'(m), 32'(!VEC[v].bad));
        wr_words_check(VEC[v].sz, int'(VEC[v].cnt), VEC[v].adr);
      end else begin
        rd_burst(VEC[v].sz, int'(VEC[v].cnt), VEC[v].adr, zeros, mk, badb, cg);
        check(mk, "R5 read marker seen", 32'(mk), 1);
        check(badb == 0, "R6 R7 read payload bits", 32'(badb), 0);
        check(cg == crc_of(int'(VEC[v].cnt) * bsz(VEC[v].sz)), "R1 R6 read CRC", cg,
              crc_of(int'(VEC[v].cnt) * bsz(VEC[v].sz)));
        check(underrun == 1'b0, "R9 no underrun with fast bus", 32'(underrun), 0);
      end
    end

    // R8: empty write and empty read
    lat = 1;
    wr_burst(2'd2, 0, 16'h0400, 2, 1'b0, m);
    check(m == 1'b1, "R8 empty write match", 32'(m), 1);
    check(n_log == 0, "R8 empty write no bus", 32'(n_log), 0);
    rd_burst(2'd0, 0, 16'h0400, zeros, mk, badb, cg);
    check(mk && zeros == 0, "R8 empty read marker first", 32'(zeros), 0);
    check(cg == 32'hFFFF_FFFF, "R8 empty read CRC", cg, 32'hFFFF_FFFF);

    // R5 and R9: slow first word gives zeros; no underrun from waiting
    lat = 20;
    rd_burst(2'd2, 1, 16'h0600, zeros, mk, badb, cg);
    check(zeros > 0, "R5 zeros before marker", 32'(zeros), 1);
    check(badb == 0 && mk, "R5 R6 slow read data", 32'(badb), 0);
    check(underrun == 1'b0, "R9 waiting is not underrun", 32'(underrun), 0);

    // R9: late second word
    lat = 60;
    rd_burst(2'd0, 3, 16'h0700, zeros, mk, badb, cg);
    check(underrun == 1'b1, "R9 underrun flagged", 32'(underrun), 1);
    repeat (300) @(negedge clk);
    check(underrun == 1'b1, "R9 underrun sticky", 32'(underrun), 1);

    // R10: new command clears flag; restart mid-burst
    lat = 1;
    issue(1'b1, 2'd0, 2, 16'h0800);
    check(underrun == 1'b0, "R10 load clears underrun", 32'(underrun), 0);
    shift1(1'b1, d);
    for (int i = 0; i < 5; i++) shift1(1'b1, d);
    wr_burst(2'd1, 2, 16'h0810, 0, 1'b0, m);
    check(m == 1'b1, "R10 restart CRC reinit", 32'(m), 1);
    wr_words_check(2'd1, 2, 16'h0810);

    finish_run();
  end

endmodule